// File: doc/BRIEF.md
# Pointer-Addressed Serial Register Target

This block is the target side of a two-wire serial (I2C) link. It gives a controller access to a small bank of 16-bit registers through an 8-bit pointer. It runs on the system clock. It oversamples the synchronised SCL and SDA lines and answers only by pulling SDA low through an output enable. A write transaction always carries a pointer byte after the address byte. Any data bytes that follow are stored, two at a time, into the register that pointer selects. A read transaction carries no pointer. It returns the register chosen by the pointer that the most recent write left behind.

The bank holds a parameterised number of read/write registers at the lowest pointer values, plus a short run of constant read-only registers at the top of the pointer space. Every other pointer value is unmapped. The target reports errors at different points in a transaction. A wrong address is refused right after the address byte. An unmapped pointer is refused right after the pointer byte. A write aimed at a read-only register is refused after each of its data bytes.

Top module: `ptr_i2c_target`

## Requirements
- R1: The target answers only the 7-bit address `TGT_ADDR` (default 0x50). It ACKs a matching address byte by holding SDA low during the ninth clock. For any other address it leaves SDA released for that ninth clock and for every later bit up to the next START, and register contents stay unchanged.
- R2: In a write (R/W bit = 0), the first byte after the address byte is always stored as the pointer. A transaction made of only the address and the pointer is legal, and it only moves the pointer.
- R3: Pointer values 0 to `NUM_RW`-1 (default 0 to 3) are read/write. Pointers 0xFE and 0xFF are read-only and hold 0xA5C3 and 0x1E07. Every other pointer value is unmapped. The target NACKs an unmapped pointer byte and leaves SDA released until the next START.
- R4: Data bytes to a read/write register are each ACKed and taken in pairs, high byte first. Each pair is committed only after the ACK of its second byte. Further pairs in the same transaction overwrite the same register. A trailing single byte is discarded.
- R5: Every data byte written to a read-only register is NACKed, and its value stays the same.
- R6: A read (R/W bit = 1) returns the register at the stored pointer, high byte then low byte, each byte MSB first. If the controller keeps ACKing, the bytes continue as high, low, high, low of the same register. An unmapped stored pointer reads as 0x0000.
- R7: Read transactions never change the stored pointer, so repeated reads return the same register.
- R8: When the controller NACKs a read byte, the target stops driving SDA until the next START.
- R9: A START (SDA falling while SCL is high) at any point, including in the middle of a byte, restarts address detection. A STOP (SDA rising while SCL is high) returns the target to idle with SDA released.
- R10: The SDA output enable changes only while SCL is low.
- R11: After reset, SDA is released, the pointer is 0 and all read/write registers hold 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | When high, the pad pulls SDA low |

## Verification
The assertions assume that each SCL low phase lasts longer than the input synchroniser plus one edge-detect register. Under that assumption, every change of the output enable that follows a synchronised falling edge lands while the raw SCL is still low. They also assume that no START or STOP is issued while the target holds SDA low, because a controller cannot produce one then. To stay inside both assumptions, the stimulus uses six-clock SCL phases. It changes SDA only in the middle of the low phase. It cuts transactions short only during bits that the controller drives.

// File: rtl/ptr_i2c_pkg.sv
// Package: shared types and sizes for the pointer-addressed serial target.
// Assumes: bytes are 8 bits and registers are two bytes wide.
package ptr_i2c_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    // Protocol engine state
    typedef enum logic [2:0] {
        ST_IDLE,    // waiting for START
        ST_RX,      // shifting in a byte from the controller
        ST_ACK,     // ninth clock of a received byte
        ST_TX,      // shifting out a read byte
        ST_MACK,    // controller ACK/NACK slot after a read byte
        ST_IGNORE   // transaction refused, wait for START or STOP
    } tgt_state_e;

    // Which byte of a write transaction is being received
    typedef enum logic [1:0] {
        PH_ADDR,
        PH_PTR,
        PH_DATA
    } rx_phase_e;

endpackage

// File: rtl/ptr_i2c_line_cond.sv
// Module: bus line conditioner.
// Synchronises SCL and SDA into the clk domain and reports SCL edges,
// START and STOP as single-cycle pulses.
// Assumes: clk is several times faster than SCL; the idle bus is high.
module ptr_i2c_line_cond #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [SYNC_N-1:0] scl_pipe;
    logic [SYNC_N-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;

    // Synchronise both lines and keep one cycle of history for edge detection
    always_ff @(posedge clk) begin : sync_lines
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_N-2:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_N-2:0], sda_i};
            scl_d    <= scl_pipe[SYNC_N-1];
            sda_d    <= sda_pipe[SYNC_N-1];
        end
    end

    assign scl_s = scl_pipe[SYNC_N-1];
    assign sda_s = sda_pipe[SYNC_N-1];

    // Decode clock edges and bus conditions from the synchronised lines
    always_comb begin : decode_cond
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = ~scl_s & scl_d;
        start_det = scl_s & scl_d & sda_d & ~sda_s;
        stop_det  = scl_s & scl_d & ~sda_d & sda_s;
    end

endmodule

// File: rtl/ptr_i2c_regbank.sv
// Module: register bank behind the serial target.
// Holds NUM_RW read/write words at pointers 0..NUM_RW-1 and RO_NUM
// constant words from pointer RO_BASE upward. Reports whether the looked-up
// pointer is mapped and whether it is read-only. An unmapped pointer reads 0.
// Assumes: wr_en is raised only for read/write pointers.
module ptr_i2c_regbank
    import ptr_i2c_pkg::*;
#(
    parameter int                     NUM_RW    = 4,
    parameter int                     RO_BASE   = 254,
    parameter int                     RO_NUM    = 2,
    parameter logic [RO_NUM*WORD_W-1:0] RO_VALUES = {16'h1E07, 16'hA5C3}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] ptr,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    output logic              ptr_valid,
    output logic              ptr_ro
);

    logic [NUM_RW-1:0][WORD_W-1:0] rw_q;

    // Store a committed word into the selected read/write register
    always_ff @(posedge clk) begin : rw_store
        if (!rst_n) begin
            rw_q <= '0;
        end else begin
            for (int k = 0; k < NUM_RW; k++) begin
                if (wr_en && int'(ptr) == k) begin
                    rw_q[k] <= wr_data;
                end
            end
        end
    end

    // Decode the pointer map and select the read word
    always_comb begin : map_lookup
        logic hit_rw;
        logic hit_ro;
        hit_rw  = 1'b0;
        hit_ro  = 1'b0;
        rd_data = '0;
        for (int k = 0; k < NUM_RW; k++) begin
            if (int'(ptr) == k) begin
                hit_rw  = 1'b1;
                rd_data = rw_q[k];
            end
        end
        for (int k = 0; k < RO_NUM; k++) begin
            if (int'(ptr) == RO_BASE + k) begin
                hit_ro  = 1'b1;
                rd_data = RO_VALUES[k*WORD_W +: WORD_W];
            end
        end
        ptr_valid = hit_rw | hit_ro;
        ptr_ro    = hit_ro;
    end

endmodule

// File: rtl/ptr_i2c_fsm.sv
// Module: protocol engine of the serial target.
// Shifts bytes in on SCL rising edges and changes the SDA enable only
// after SCL falling edges. Decodes the address, stores the pointer,
// assembles two-byte writes and serialises two-byte reads.
// Assumes: edge and condition pulses come from ptr_i2c_line_cond, and the
// bank answers pointer lookups combinationally.
module ptr_i2c_fsm
    import ptr_i2c_pkg::*;
#(
    parameter logic [6:0] TGT_ADDR = 7'h50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              ptr_valid,
    input  logic              ptr_ro,
    input  logic [WORD_W-1:0] rd_data,
    output logic [BYTE_W-1:0] ptr_q,
    output logic              wr_en,
    output logic [WORD_W-1:0] wr_data,
    output logic              sda_oe,
    output tgt_state_e        state_o
);

    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

    tgt_state_e        state;
    rx_phase_e         phase;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;
    logic [BYTE_W-1:0] last_byte;
    logic [BYTE_W-1:0] hold_msb;
    logic              rnw;
    logic              lo_next;
    logic              tx_lsb;
    logic              mack;
    logic              sda_oe_q;
    logic              wr_en_q;
    logic [WORD_W-1:0] wr_data_q;
    logic [BYTE_W-1:0] rx_next;

    assign rx_next = {rx_sh[BYTE_W-2:0], sda_s};

    // Sequence the bus protocol: receive, acknowledge, transmit, refuse
    always_ff @(posedge clk) begin : proto_seq
        wr_en_q <= 1'b0;
        if (!rst_n) begin
            state     <= ST_IDLE;
            phase     <= PH_ADDR;
            bit_cnt   <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            last_byte <= '0;
            hold_msb  <= '0;
            rnw       <= 1'b0;
            lo_next   <= 1'b0;
            tx_lsb    <= 1'b0;
            mack      <= 1'b0;
            sda_oe_q  <= 1'b0;
            ptr_q     <= '0;
            wr_data_q <= '0;
        end else if (start_det) begin
            state    <= ST_RX;
            phase    <= PH_ADDR;
            bit_cnt  <= '0;
            lo_next  <= 1'b0;
            sda_oe_q <= 1'b0;
        end else if (stop_det) begin
            state    <= ST_IDLE;
            sda_oe_q <= 1'b0;
        end else begin
            case (state)
                ST_RX: begin
                    if (scl_rise && bit_cnt != CNT_FULL) begin
                        rx_sh   <= rx_next;
                        bit_cnt <= bit_cnt + 1'b1;
                        if (phase == PH_PTR && bit_cnt == CNT_FULL - 1'b1) begin
                            ptr_q <= rx_next;
                        end
                    end else if (scl_fall && bit_cnt == CNT_FULL) begin
                        bit_cnt <= '0;
                        case (phase)
                            PH_ADDR: begin
                                if (rx_sh[BYTE_W-1:1] == TGT_ADDR) begin
                                    rnw      <= rx_sh[0];
                                    sda_oe_q <= 1'b1;
                                    state    <= ST_ACK;
                                end else begin
                                    state    <= ST_IGNORE;
                                end
                            end
                            PH_PTR: begin
                                if (ptr_valid) begin
                                    sda_oe_q <= 1'b1;
                                    state    <= ST_ACK;
                                end else begin
                                    state    <= ST_IGNORE;
                                end
                            end
                            default: begin
                                last_byte <= rx_sh;
                                sda_oe_q  <= ~ptr_ro;
                                state     <= ST_ACK;
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        if (phase == PH_ADDR && rnw) begin
                            tx_sh    <= rd_data[WORD_W-1:BYTE_W];
                            sda_oe_q <= ~rd_data[WORD_W-1];
                            tx_lsb   <= 1'b1;
                            bit_cnt  <= CNT_W'(1);
                            state    <= ST_TX;
                        end else begin
                            sda_oe_q <= 1'b0;
                            state    <= ST_RX;
                            if (phase == PH_ADDR) begin
                                phase <= PH_PTR;
                            end else if (phase == PH_PTR) begin
                                phase <= PH_DATA;
                            end else if (!ptr_ro) begin
                                if (lo_next) begin
                                    wr_en_q   <= 1'b1;
                                    wr_data_q <= {hold_msb, last_byte};
                                    lo_next   <= 1'b0;
                                end else begin
                                    hold_msb <= last_byte;
                                    lo_next  <= 1'b1;
                                end
                            end
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (bit_cnt == CNT_FULL) begin
                            sda_oe_q <= 1'b0;
                            state    <= ST_MACK;
                        end else begin
                            sda_oe_q <= ~tx_sh[BYTE_W-2];
                            tx_sh    <= tx_sh << 1;
                            bit_cnt  <= bit_cnt + 1'b1;
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        mack <= ~sda_s;
                    end else if (scl_fall) begin
                        if (mack) begin
                            if (tx_lsb) begin
                                tx_sh    <= rd_data[BYTE_W-1:0];
                                sda_oe_q <= ~rd_data[BYTE_W-1];
                            end else begin
                                tx_sh    <= rd_data[WORD_W-1:BYTE_W];
                                sda_oe_q <= ~rd_data[WORD_W-1];
                            end
                            tx_lsb  <= ~tx_lsb;
                            bit_cnt <= CNT_W'(1);
                            state   <= ST_TX;
                        end else begin
                            sda_oe_q <= 1'b0;
                            state    <= ST_IGNORE;
                        end
                    end
                end
                default: begin
                    sda_oe_q <= 1'b0;
                end
            endcase
        end
    end

    assign sda_oe  = sda_oe_q;
    assign wr_en   = wr_en_q;
    assign wr_data = wr_data_q;
    assign state_o = state;

endmodule

// File: rtl/ptr_i2c_target.sv
// Module: pointer-addressed serial register target (top).
// Joins the line conditioner, the protocol engine and the register bank.
// SDA is open drain: sda_oe high means the pad pulls SDA low.
// Assumes: scl_i and sda_i are the pad levels, including the target's own drive.
module ptr_i2c_target
    import ptr_i2c_pkg::*;
#(
    parameter logic [6:0]               TGT_ADDR  = 7'h50,
    parameter int                       NUM_RW    = 4,
    parameter int                       RO_BASE   = 254,
    parameter int                       RO_NUM    = 2,
    parameter logic [RO_NUM*WORD_W-1:0] RO_VALUES = {16'h1E07, 16'hA5C3},
    parameter int                       SYNC_N    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);

    logic              scl_s;
    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic              ptr_valid;
    logic              ptr_ro;
    logic              wr_en;
    logic [WORD_W-1:0] wr_data;
    logic [WORD_W-1:0] rd_data;
    logic [BYTE_W-1:0] ptr_q;
    tgt_state_e        fsm_state;

    ptr_i2c_line_cond #(.SYNC_N(SYNC_N)) u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    ptr_i2c_fsm #(.TGT_ADDR(TGT_ADDR)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .ptr_valid (ptr_valid),
        .ptr_ro    (ptr_ro),
        .rd_data   (rd_data),
        .ptr_q     (ptr_q),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .sda_oe    (sda_oe),
        .state_o   (fsm_state)
    );

    ptr_i2c_regbank #(
        .NUM_RW    (NUM_RW),
        .RO_BASE   (RO_BASE),
        .RO_NUM    (RO_NUM),
        .RO_VALUES (RO_VALUES)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .ptr       (ptr_q),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .ptr_valid (ptr_valid),
        .ptr_ro    (ptr_ro)
    );

endmodule

// File: rtl/ptr_i2c_target_chk.sv
// Module: property checker for ptr_i2c_target, attached by bind.
// Assumes: SCL low phases outlast the synchroniser latency, and no START or
// STOP is issued while the target holds SDA low.
module ptr_i2c_target_chk
    import ptr_i2c_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       sda_oe,
    input logic       start_det,
    input logic       stop_det,
    input logic       wr_en,
    input logic       ptr_valid,
    input logic       ptr_ro,
    input tgt_state_e fsm_state
);

    assert_start_rearms_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (fsm_state == ST_RX && !sda_oe));

    assert_stop_idles_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (fsm_state == ST_IDLE && !sda_oe));

    assert_oe_moves_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_i);

    assert_commit_rw_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (ptr_valid && !ptr_ro));

    assert_commit_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    assert_refused_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_IGNORE) |-> !sda_oe);

    assert_reset_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !sda_oe);

endmodule

bind ptr_i2c_target ptr_i2c_target_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_oe    (sda_oe),
    .start_det (start_det),
    .stop_det  (stop_det),
    .wr_en     (wr_en),
    .ptr_valid (ptr_valid),
    .ptr_ro    (ptr_ro),
    .fsm_state (fsm_state)
);

// File: tb/ptr_i2c_target_tb_top.sv
// Bench: drives a bit-level controller model and checks every response at the pins.
module ptr_i2c_target_tb_top;

    localparam logic [6:0] TA     = 7'h50;
    localparam int         NRW    = 4;
    localparam logic [7:0] AW     = {TA, 1'b0};
    localparam logic [7:0] AR     = {TA, 1'b1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_oe;
    logic sda_line;
    int   total = 0;
    int   bad = 0;
    int   oe_viol = 0;
    bit   done = 1'b0;

    assign sda_line = m_sda & ~sda_oe;

    always #10 clk = ~clk;

    ptr_i2c_target #(.TGT_ADDR(TA), .NUM_RW(NRW)) dut_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (m_scl),
        .sda_i  (sda_line),
        .sda_oe (sda_oe)
    );

    // Watch for enable changes while SCL is high (R10)
    logic oe_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n && sda_oe !== oe_prev && m_scl) oe_viol++;
        oe_prev = sda_oe;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put_bit(input logic b, output logic rb);
        tick(3); m_sda = b;
        tick(3); m_scl = 1'b1;
        tick(3); rb = sda_line;
        tick(3); m_scl = 1'b0;
    endtask

    task automatic do_start();
        tick(3); m_sda = 1'b1;
        tick(3); m_scl = 1'b1;
        tick(3); m_sda = 1'b0;
        tick(3); m_scl = 1'b0;
    endtask

    task automatic do_stop();
        tick(3); m_sda = 1'b0;
        tick(3); m_scl = 1'b1;
        tick(3); m_sda = 1'b1;
        tick(3);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) put_bit(b[i], r);
        put_bit(1'b1, r);
        ack = ~r;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] d);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            put_bit(1'b1, r);
            d[i] = r;
        end
        put_bit(~give_ack, r);
    endtask

    // Full write of one word: returns ACKs of address, pointer, high, low
    task automatic write_word(input logic [7:0] p, input logic [15:0] v, output logic [3:0] acks);
        do_start();
        send_byte(AW, acks[3]);
        send_byte(p, acks[2]);
        send_byte(v[15:8], acks[1]);
        send_byte(v[7:0], acks[0]);
        do_stop();
    endtask

    // Read two bytes at the stored pointer
    task automatic read_cur(output logic [15:0] v, output logic aok);
        do_start();
        send_byte(AR, aok);
        recv_byte(1'b1, v[15:8]);
        recv_byte(1'b0, v[7:0]);
        do_stop();
    endtask

    // Move the pointer, then repeated START and read two bytes
    task automatic read_at(input logic [7:0] p, output logic [15:0] v, output logic [2:0] acks);
        do_start();
        send_byte(AW, acks[2]);
        send_byte(p, acks[1]);
        do_start();
        send_byte(AR, acks[0]);
        recv_byte(1'b1, v[15:8]);
        recv_byte(1'b0, v[7:0]);
        do_stop();
    endtask

    function automatic logic [15:0] pat(input int p);
        return 16'h3C5A ^ 16'(p * 16'h0123);
    endfunction

    initial begin : main
        logic [15:0] v;
        logic [7:0]  b;
        logic [3:0]  a4;
        logic [2:0]  a3;
        logic        a;
        tick(5);
        chk("R11 sda released in reset", {31'd0, sda_oe}, 32'd0);
        rst_n = 1'b1;
        tick(4);
        chk("R11 sda released after reset", {31'd0, sda_line}, 32'd1);
        read_cur(v, a);
        chk("R1 address ack", {31'd0, a}, 32'd1);
        chk("R11 register 0 clear, pointer 0", {16'd0, v}, 32'd0);

        // Write then read back every read/write register
        for (int p = 0; p < NRW; p++) begin
            write_word(8'(p), pat(p), a4);
            chk("R4 write acks", {28'd0, a4}, 32'hF);
        end
        for (int p = NRW - 1; p >= 0; p--) begin
            read_at(8'(p), v, a3);
            chk("R2 pointer write then read acks", {29'd0, a3}, 32'h7);
            chk("R6 readback", {16'd0, v}, {16'd0, pat(p)});
        end

        // Four-byte read wraps within the register, pointer sticky
        read_at(8'd2, v, a3);
        do_start();
        send_byte(AR, a);
        recv_byte(1'b1, b); chk("R6 wrap byte0", {24'd0, b}, {24'd0, pat(2)} >> 8);
        recv_byte(1'b1, b); chk("R6 wrap byte1", {24'd0, b}, {24'd0, pat(2) & 16'hFF});
        recv_byte(1'b1, b); chk("R6 wrap byte2", {24'd0, b}, {24'd0, pat(2)} >> 8);
        recv_byte(1'b0, b); chk("R6 wrap byte3", {24'd0, b}, {24'd0, pat(2) & 16'hFF});
        do_stop();
        read_cur(v, a);
        chk("R7 pointer unchanged by reads", {16'd0, v}, {16'd0, pat(2)});

        // Pointer-only write then plain read
        do_start(); send_byte(AW, a); send_byte(8'd3, a); do_stop();
        chk("R2 pointer-only write ack", {31'd0, a}, 32'd1);
        read_cur(v, a);
        chk("R2 pointer-only moved pointer", {16'd0, v}, {16'd0, pat(3)});

        // Single trailing byte discarded, odd count keeps first pair
        do_start(); send_byte(AW, a); send_byte(8'd1, a); send_byte(8'h77, a); do_stop();
        chk("R4 lone byte acked", {31'd0, a}, 32'd1);
        read_at(8'd1, v, a3);
        chk("R4 lone byte discarded", {16'd0, v}, {16'd0, pat(1)});
        do_start(); send_byte(AW, a); send_byte(8'd3, a);
        send_byte(8'h12, a); send_byte(8'h34, a); send_byte(8'h56, a); do_stop();
        read_at(8'd3, v, a3);
        chk("R4 three bytes keep first pair", {16'd0, v}, 32'h1234);
        do_start(); send_byte(AW, a); send_byte(8'd0, a);
        send_byte(8'hAB, a); send_byte(8'hCD, a); send_byte(8'hEF, a); send_byte(8'h01, a); do_stop();
        read_at(8'd0, v, a3);
        chk("R4 second pair overwrites", {16'd0, v}, 32'hEF01);

        // Read-only registers
        write_word(8'hFE, 16'h0000, a4);
        chk("R5 read-only write acks", {28'd0, a4}, 32'hC);
        read_at(8'hFE, v, a3);
        chk("R5 read-only value kept", {16'd0, v}, 32'hA5C3);
        read_at(8'hFF, v, a3);
        chk("R3 second read-only value", {16'd0, v}, 32'h1E07);

        // Sweep every pointer value for the ACK decision
        for (int p = 0; p < 256; p++) begin
            do_start(); send_byte(AW, a); send_byte(8'(p), a); do_stop();
            chk($sformatf("R3 pointer %0d ack", p), {31'd0, a},
                {31'd0, (p < NRW || p >= 254)});
        end

        // Unmapped pointer: later bytes refused, reads give zero
        write_word(8'h10, 16'h9999, a4);
        chk("R3 unmapped pointer acks", {28'd0, a4}, 32'h8);
        read_cur(v, a);
        chk("R6 unmapped reads zero", {16'd0, v}, 32'd0);

        // Sweep every other address: refused, nothing written
        for (int ad = 0; ad < 128; ad++) begin
            if (ad != int'(TA)) begin
                write_word(8'd0, 16'h0000, a4);
                write_word(8'd0, 16'hEF01, a4);
                do_start();
                send_byte({7'(ad), 1'b0}, a4[3]);
                send_byte(8'd0, a4[2]);
                send_byte(8'h00, a4[1]);
                send_byte(8'h00, a4[0]);
                do_stop();
                chk($sformatf("R1 address %0d refused", ad), {28'd0, a4}, 32'd0);
                if (ad > 8) break;
            end
        end
        for (int ad = 9; ad < 128; ad++) begin
            if (ad != int'(TA)) begin
                do_start();
                send_byte({7'(ad), 1'b0}, a4[3]);
                send_byte(8'd0, a4[2]);
                send_byte(8'h00, a4[1]);
                do_stop();
                chk($sformatf("R1 address %0d refused", ad), {29'd0, a4[3:1]}, 32'd0);
            end
        end
        read_at(8'd0, v, a3);
        chk("R1 other addresses wrote nothing", {16'd0, v}, 32'hEF01);
        do_start(); send_byte({7'h51, 1'b1}, a); recv_byte(1'b0, b); do_stop();
        chk("R1 wrong read address nack", {31'd0, a}, 32'd0);
        chk("R1 wrong read address silent", {24'd0, b}, 32'hFF);

        // Controller NACK ends read output
        do_start(); send_byte(AR, a);
        recv_byte(1'b0, b);
        chk("R8 first byte before nack", {24'd0, b}, 32'hEF);
        recv_byte(1'b0, b);
        chk("R8 released after nack", {24'd0, b}, 32'hFF);
        do_stop();

        // Aborted writes recover at the next START or STOP
        do_start(); send_byte(AW, a); send_byte(8'd1, a);
        for (int i = 0; i < 4; i++) put_bit(1'b0, a);
        write_word(8'd1, 16'h4242, a4);
        chk("R9 restart mid-byte acks", {28'd0, a4}, 32'hF);
        do_start(); send_byte(AW, a);
        for (int i = 0; i < 3; i++) put_bit(1'b1, a);
        do_stop();
        read_at(8'd1, v, a3);
        chk("R9 recovered after abort", {29'd0, a3}, 32'h7);
        chk("R9 write after abort", {16'd0, v}, 32'h4242);
        chk("R9 idle after stop", {31'd0, sda_oe}, 32'd0);

        chk("R10 enable never moved with SCL high", oe_viol, 32'd0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : watchdog
        repeat (195000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule